// File: doc/BRIEF.md
# Virtual interrupt list-register bank

This block holds the list of virtual interrupts that a hypervisor has queued for one virtual CPU interface. It has four 32-bit entries and one control word. The hypervisor writes and reads them through a word-wide register port that has a synchronous write strobe. Each entry records the following:

- a virtual interrupt number
- the CPU that raised it
- a five-bit priority
- a two-bit life-cycle state (pending, active, or both)
- a few flags that are stored and returned but cause no action

The bank evaluates its contents continuously. It reports the entry that should be delivered next, which is the pending entry with the smallest priority number, with ties going to the lower slot. It also reports how many entries are pending and how many are valid. For the interrupt number and CPU number on the query inputs, it returns the first valid slot that holds that pair. It raises the virtual IRQ line whenever the control word is enabled and something is pending.

The register file is the only clocked state. The selector, the counters and the lookup are combinational functions of the stored entries, so each of them follows a write on the clock edge that performs it. There is no state machine; the life-cycle state of each entry is the field written by the hypervisor.

Top module: `lrb_bank`

## Requirements
- R1: An asynchronous active-low reset clears every entry and the control word to zero. While reset is held and after it is released: reads return 0, `top_valid`, `hit` and `virq` are 0, both counts are 0, and both index outputs are 0.
- R2: The entries are at byte offsets 0x100, 0x104, 0x108 and 0x10C (slots 0 to 3). Each entry stores these fields, and all other bits (22:20 and 18:13) always read as zero:

  | Bits | Field |
  |---|---|
  | 31 | hardware flag |
  | 30 | group flag |
  | 29:28 | state |
  | 27:23 | priority |
  | 19 | end-of-service request |
  | 12:10 | source CPU |
  | 9:0 | interrupt number |

  For example, writing 0xFFFFFFFF reads back as 0xFF881FFF. Bit 31 is only stored and returned.
- R3: In the state field, bit 28 means pending and bit 29 means active. State 0 is an empty slot; any other value is a valid slot. An entry that is active only is never selected for delivery.
- R4: When one or more entries are pending, `top_valid` is 1 and `top_idx` is the pending slot with the smallest priority value. Equal priorities resolve to the lower slot number. When nothing is pending, `top_valid` is 0 and `top_idx` is 0.
- R5: `hit` is 1 and `hit_idx` is the lowest-numbered valid slot whose bits 9:0 equal `q_vid` and whose bits 12:10 equal `q_cpu`. When no slot matches, `hit` and `hit_idx` are 0. Empty slots never match.
- R6: `pend_cnt` counts the entries whose state bit 28 is set, and `valid_cnt` counts the entries whose state is nonzero.
- R7: The control word at offset 0x000 stores the following bits, and all other bits read as zero (a write of 0xFFFFFFFF reads back 0xF800000F):

  | Bits | Field |
  |---|---|
  | 0 | enable |
  | 1 | underflow enable |
  | 2 | missing-entry enable |
  | 3 | nothing-pending enable |
  | 31:27 | end-of-service count |
- R8: `virq` is 1 exactly when control bit 0 is 1 and at least one entry is pending. It reflects a write from the clock edge that performs that write.
- R9: Reads of any other offset, including misaligned ones such as 0x102, return zero. Writes to those offsets change no entry and do not change the control word.
- R10: `rdata` is a combinational read of the addressed word. During a cycle that writes that word, it shows the old contents, and the new value appears after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 12 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| q_vid | input | 10 | Interrupt number to look up |
| q_cpu | input | 3 | Source CPU to look up |
| top_valid | output | 1 | Some entry is pending |
| top_idx | output | 2 | Slot of the next entry to deliver |
| pend_cnt | output | 3 | Number of pending entries |
| valid_cnt | output | 3 | Number of valid entries |
| hit | output | 1 | Lookup found a matching valid slot |
| hit_idx | output | 2 | Slot found by the lookup |
| virq | output | 1 | Virtual IRQ to the CPU |

## Verification
A single register write can change the delivery choice and the lookup result in the same cycle. The bench provokes this in three ways:

- It writes an active-only entry with the same interrupt number into a lower slot, so that the lookup moves to that slot while the selector must stay where it was.
- It writes a duplicate pair into a second slot at a priority equal to the current winner, which exercises the tie rule in the selector and first-match in the lookup at once.
- It invalidates the slot that was winning.

For each write, the bench compares `rdata` just before the edge against the old contents. After the edge it compares every output against a model that it updates from the requirements.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
    localparam int WORD_W  = 32;
    localparam int PRIO_W  = 5;
    localparam int VID_W   = 10;
    localparam int CPU_W   = 3;
    localparam int ST_W    = 2;

    // entry field positions (a neighbour decodes these)
    localparam int ST_LO   = 28;
    localparam int PRIO_LO = 23;
    localparam int CPU_LO  = 10;
    localparam int VID_LO  = 0;

    // bits kept by storage; others read as zero
    localparam logic [WORD_W-1:0] ENTRY_KEEP = 32'hFF88_1FFF;
    localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'hF800_000F;

    localparam int CTRL_OFS = 32'h000;
    localparam int LR_BASE  = 32'h100;
    localparam int LR_STEP  = 4;

    localparam int ST_PEND_BIT = 0;
    localparam int EN_BIT      = 0;
endpackage

// File: rtl/lrb_regs.sv
module lrb_regs
    import lrb_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int ADDR_W = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [WORD_W-1:0]                 wdata,
    output logic [WORD_W-1:0]                 rdata,
    output logic                              ctrl_en,
    output logic [NUM_LR-1:0][ST_W-1:0]       ent_st,
    output logic [NUM_LR-1:0][PRIO_W-1:0]     ent_prio,
    output logic [NUM_LR-1:0][VID_W-1:0]      ent_vid,
    output logic [NUM_LR-1:0][CPU_W-1:0]      ent_cpu
);
    logic [WORD_W-1:0]             ctrl_q;
    logic [NUM_LR-1:0][WORD_W-1:0] lr_q;
    logic [NUM_LR-1:0]             lr_sel;
    logic                          ctrl_sel;

    assign ctrl_sel = (addr == ADDR_W'(CTRL_OFS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && ctrl_sel) begin
            ctrl_q <= wdata & CTRL_KEEP;
        end
    end

    assign ctrl_en = ctrl_q[EN_BIT];

    for (genvar g = 0; g < NUM_LR; g++) begin : g_entry
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(LR_BASE + LR_STEP * g);

        assign lr_sel[g] = (addr == OFS);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lr_q[g] <= '0;
            end else if (wr_en && lr_sel[g]) begin
                lr_q[g] <= wdata & ENTRY_KEEP;
            end
        end

        assign ent_st[g]   = lr_q[g][ST_LO   +: ST_W];
        assign ent_prio[g] = lr_q[g][PRIO_LO +: PRIO_W];
        assign ent_cpu[g]  = lr_q[g][CPU_LO  +: CPU_W];
        assign ent_vid[g]  = lr_q[g][VID_LO  +: VID_W];
    end

    always_comb begin
        rdata = ctrl_sel ? ctrl_q : '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (lr_sel[i]) begin
                rdata = lr_q[i];
            end
        end
    end
endmodule

// File: rtl/lrb_pick.sv
module lrb_pick
    import lrb_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = $clog2(NUM_LR),
    localparam int CNT_W = $clog2(NUM_LR + 1)
) (
    input  logic [NUM_LR-1:0][ST_W-1:0]   ent_st,
    input  logic [NUM_LR-1:0][PRIO_W-1:0] ent_prio,
    output logic                          top_valid,
    output logic [IDX_W-1:0]              top_idx,
    output logic [CNT_W-1:0]              pend_cnt,
    output logic [CNT_W-1:0]              valid_cnt
);
    localparam int BEST_W = PRIO_W + 3;

    logic [NUM_LR-1:0] is_pend;
    logic [NUM_LR-1:0] is_valid;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_flag
        assign is_pend[g]  = ent_st[g][ST_PEND_BIT];
        assign is_valid[g] = |ent_st[g];
    end

    // strict less-than from an all-ones threshold: lower slot keeps a tie
    always_comb begin
        logic [BEST_W-1:0] best;
        best      = '1;
        top_valid = 1'b0;
        top_idx   = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            if (is_pend[i] && (BEST_W'(ent_prio[i]) < best)) begin
                best      = BEST_W'(ent_prio[i]);
                top_idx   = IDX_W'(i);
                top_valid = 1'b1;
            end
        end
    end

    always_comb begin
        pend_cnt  = '0;
        valid_cnt = '0;
        for (int i = 0; i < NUM_LR; i++) begin
            pend_cnt  = pend_cnt  + CNT_W'(is_pend[i]);
            valid_cnt = valid_cnt + CNT_W'(is_valid[i]);
        end
    end
endmodule

// File: rtl/lrb_match.sv
module lrb_match
    import lrb_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = $clog2(NUM_LR)
) (
    input  logic [NUM_LR-1:0][ST_W-1:0]  ent_st,
    input  logic [NUM_LR-1:0][VID_W-1:0] ent_vid,
    input  logic [NUM_LR-1:0][CPU_W-1:0] ent_cpu,
    input  logic [VID_W-1:0]             q_vid,
    input  logic [CPU_W-1:0]             q_cpu,
    output logic                         hit,
    output logic [IDX_W-1:0]             hit_idx
);
    logic [NUM_LR-1:0] eq;

    for (genvar g = 0; g < NUM_LR; g++) begin : g_cmp
        assign eq[g] = (|ent_st[g]) && (ent_vid[g] == q_vid) && (ent_cpu[g] == q_cpu);
    end

    // first match by ascending slot: scan downward so the lowest wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_LR - 1; i >= 0; i--) begin
            if (eq[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lrb_bank.sv
module lrb_bank
    import lrb_pkg::*;
#(
    parameter int NUM_LR = 4,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NUM_LR),
    localparam int CNT_W = $clog2(NUM_LR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [VID_W-1:0]  q_vid,
    input  logic [CPU_W-1:0]  q_cpu,
    output logic              top_valid,
    output logic [IDX_W-1:0]  top_idx,
    output logic [CNT_W-1:0]  pend_cnt,
    output logic [CNT_W-1:0]  valid_cnt,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              virq
);
    logic                          ctrl_en;
    logic [NUM_LR-1:0][ST_W-1:0]   ent_st;
    logic [NUM_LR-1:0][PRIO_W-1:0] ent_prio;
    logic [NUM_LR-1:0][VID_W-1:0]  ent_vid;
    logic [NUM_LR-1:0][CPU_W-1:0]  ent_cpu;

    lrb_regs #(.NUM_LR(NUM_LR), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .ctrl_en  (ctrl_en),
        .ent_st   (ent_st),
        .ent_prio (ent_prio),
        .ent_vid  (ent_vid),
        .ent_cpu  (ent_cpu)
    );

    lrb_pick #(.NUM_LR(NUM_LR)) u_pick (
        .ent_st    (ent_st),
        .ent_prio  (ent_prio),
        .top_valid (top_valid),
        .top_idx   (top_idx),
        .pend_cnt  (pend_cnt),
        .valid_cnt (valid_cnt)
    );

    lrb_match #(.NUM_LR(NUM_LR)) u_match (
        .ent_st  (ent_st),
        .ent_vid (ent_vid),
        .ent_cpu (ent_cpu),
        .q_vid   (q_vid),
        .q_cpu   (q_cpu),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign virq = ctrl_en & top_valid;
endmodule

// File: rtl/lrb_bank_chk.sv
module lrb_bank_chk
    import lrb_pkg::*;
#(
    parameter int NUM_LR = 4,
    localparam int IDX_W = $clog2(NUM_LR),
    localparam int CNT_W = $clog2(NUM_LR + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ctrl_en,
    input logic [NUM_LR-1:0][ST_W-1:0] ent_st,
    input logic [NUM_LR-1:0][VID_W-1:0] ent_vid,
    input logic [NUM_LR-1:0][CPU_W-1:0] ent_cpu,
    input logic [VID_W-1:0]            q_vid,
    input logic [CPU_W-1:0]            q_cpu,
    input logic                        top_valid,
    input logic [IDX_W-1:0]            top_idx,
    input logic [CNT_W-1:0]            pend_cnt,
    input logic [CNT_W-1:0]            valid_cnt,
    input logic                        hit,
    input logic [IDX_W-1:0]            hit_idx,
    input logic                        virq
);
    // R4: the chosen slot really is pending
    a_r4_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ent_st[top_idx][ST_PEND_BIT]);

    // R4: no choice means nothing counted as pending and index parked at 0
    a_r4_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !top_valid |-> (pend_cnt == '0 && top_idx == '0));

    // R6: pending entries are a subset of valid ones
    a_r6_pend_le_valid: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= valid_cnt);

    // R5: a reported hit names a valid slot holding the query pair
    a_r5_hit_true: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ent_st[hit_idx] != '0 && ent_vid[hit_idx] == q_vid
                 && ent_cpu[hit_idx] == q_cpu));

    // R8: the IRQ only rises with something counted pending
    a_r8_virq_pending: assert property (@(posedge clk) disable iff (!rst_n)
        virq |-> pend_cnt != '0);

    // R8: the IRQ stays low while the enable is clear
    a_r8_virq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !virq);
endmodule

bind lrb_bank lrb_bank_chk #(.NUM_LR(NUM_LR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_en   (ctrl_en),
    .ent_st    (ent_st),
    .ent_vid   (ent_vid),
    .ent_cpu   (ent_cpu),
    .q_vid     (q_vid),
    .q_cpu     (q_cpu),
    .top_valid (top_valid),
    .top_idx   (top_idx),
    .pend_cnt  (pend_cnt),
    .valid_cnt (valid_cnt),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .virq      (virq)
);

// File: tb/lrb_bank_bench.sv
module lrb_bank_bench;
    localparam int N = 4;
    localparam logic [31:0] E_KEEP = 32'hFF88_1FFF;
    localparam logic [31:0] C_KEEP = 32'hF800_000F;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [9:0]  q_vid;
    logic [2:0]  q_cpu;
    logic        top_valid;
    logic [1:0]  top_idx;
    logic [2:0]  pend_cnt;
    logic [2:0]  valid_cnt;
    logic        hit;
    logic [1:0]  hit_idx;
    logic        virq;

    always #4 clk = ~clk;

    lrb_bank u_lrb_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .q_vid(q_vid), .q_cpu(q_cpu), .top_valid(top_valid),
        .top_idx(top_idx), .pend_cnt(pend_cnt), .valid_cnt(valid_cnt),
        .hit(hit), .hit_idx(hit_idx), .virq(virq)
    );

    typedef struct {
        string       req;
        logic [31:0] rd;
        logic        tv;
        logic [1:0]  ti;
        logic [2:0]  pc;
        logic [2:0]  vc;
        logic        ht;
        logic [1:0]  hi;
        logic        vq;
    } exp_t;

    exp_t        sbq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [31:0] m_lr[N];
    logic [31:0] m_ctrl;

    function automatic logic [31:0] mk(logic [1:0] st, logic [4:0] pr,
                                       logic [2:0] cpu, logic [9:0] vid);
        return {2'b00, st, pr, 3'b000, 1'b0, 6'b0, cpu, vid};
    endfunction

    function automatic logic [31:0] m_read(logic [11:0] a);
        if (a == 12'h000) return m_ctrl;
        for (int i = 0; i < N; i++)
            if (a == 12'h100 + 12'(4 * i)) return m_lr[i];
        return 32'h0;
    endfunction

    function automatic exp_t model(string req);
        exp_t e;
        int   best;
        e.req = req;
        e.rd  = m_read(addr);
        e.tv = 1'b0; e.ti = 2'd0; e.pc = 3'd0; e.vc = 3'd0; e.ht = 1'b0; e.hi = 2'd0;
        best = 255;
        for (int i = 0; i < N; i++) begin
            if (m_lr[i][28]) begin
                e.pc = e.pc + 3'd1;
                if (int'(m_lr[i][27:23]) < best) begin
                    best = int'(m_lr[i][27:23]);
                    e.ti = 2'(i);
                    e.tv = 1'b1;
                end
            end
            if (m_lr[i][29:28] != 2'b00) e.vc = e.vc + 3'd1;
        end
        for (int i = N - 1; i >= 0; i--)
            if (m_lr[i][29:28] != 2'b00 && m_lr[i][9:0] == q_vid && m_lr[i][12:10] == q_cpu) begin
                e.ht = 1'b1;
                e.hi = 2'(i);
            end
        e.vq = m_ctrl[0] & e.tv;
        return e;
    endfunction

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // driver: one access, then push what the outputs must show after the edge
    task automatic op(bit we, logic [11:0] a, logic [31:0] d,
                      logic [9:0] qv, logic [2:0] qc, string req);
        @(negedge clk);
        wr_en = we; addr = a; wdata = d; q_vid = qv; q_cpu = qc;
        #1;
        if (we) cmp({req, "/R10"}, "rdata before edge", rdata, m_read(a));
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (we) begin
            if (a == 12'h000) m_ctrl = d & C_KEEP;
            for (int i = 0; i < N; i++)
                if (a == 12'h100 + 12'(4 * i)) m_lr[i] = d & E_KEEP;
        end
        sbq.push_back(model(req));
        wait (sbq.size() == 0);
    endtask

    // monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq[0];
            cmp(e.req, "rdata", rdata, e.rd);
            cmp(e.req, "top_valid", 32'(top_valid), 32'(e.tv));
            cmp(e.req, "top_idx", 32'(top_idx), 32'(e.ti));
            cmp(e.req, "pend_cnt", 32'(pend_cnt), 32'(e.pc));
            cmp(e.req, "valid_cnt", 32'(valid_cnt), 32'(e.vc));
            cmp(e.req, "hit", 32'(hit), 32'(e.ht));
            cmp(e.req, "hit_idx", 32'(hit_idx), 32'(e.hi));
            cmp(e.req, "virq", 32'(virq), 32'(e.vq));
            void'(sbq.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_lr[i] = 32'h0;
        m_ctrl = 32'h0;
        rst_n = 1'b0; wr_en = 1'b0; addr = 12'h100; wdata = 32'h0; q_vid = 10'h0; q_cpu = 3'h0;
        repeat (3) @(negedge clk);
        // R1: values held in reset
        cmp("R1", "rdata in reset", rdata, 32'h0);
        cmp("R1", "top_valid in reset", 32'(top_valid), 32'h0);
        cmp("R1", "hit in reset", 32'(hit), 32'h0);
        cmp("R1", "virq in reset", 32'(virq), 32'h0);
        cmp("R1", "valid_cnt in reset", 32'(valid_cnt), 32'h0);
        rst_n = 1'b1;
        op(0, 12'h100, 32'h0, 10'h0, 3'h0, "R1");

        // R7: control word keeps only its defined bits
        op(1, 12'h000, 32'hFFFF_FFFF, 10'h0, 3'h0, "R7");
        cmp("R7", "ctrl readback", rdata, 32'hF800_000F);

        // R2: full entry pattern; reserved bits vanish, bit 31 kept
        op(1, 12'h10C, 32'hFFFF_FFFF, 10'h3FF, 3'h7, "R2");
        cmp("R2", "entry readback", rdata, 32'hFF88_1FFF);
        cmp("R8", "virq once pending", 32'(virq), 32'h1);

        // R4: equal priority in slots 1 and 2 -> slot 1
        op(1, 12'h104, mk(2'b01, 5'd4, 3'd2, 10'h021), 10'h021, 3'd2, "R4");
        op(1, 12'h108, mk(2'b01, 5'd4, 3'd2, 10'h021), 10'h021, 3'd2, "R4");
        cmp("R4", "tie to lower slot", 32'(top_idx), 32'd1);
        cmp("R5", "duplicate first match", 32'(hit_idx), 32'd1);

        // R3: active-only priority 0 in slot 0 is not chosen but is matched
        op(1, 12'h100, mk(2'b10, 5'd0, 3'd2, 10'h021), 10'h021, 3'd2, "R3");
        cmp("R3", "active-only ignored", 32'(top_idx), 32'd1);
        cmp("R6", "valid count", 32'(valid_cnt), 32'd4);
        cmp("R6", "pending count", 32'(pend_cnt), 32'd3);

        // R5: empty slot 1, move slot 0 to another CPU -> slot 2
        op(1, 12'h104, mk(2'b00, 5'd4, 3'd2, 10'h021), 10'h021, 3'd2, "R5");
        op(1, 12'h100, mk(2'b10, 5'd0, 3'd3, 10'h021), 10'h021, 3'd2, "R5");
        cmp("R5", "match after invalidate", 32'(hit_idx), 32'd2);
        op(0, 12'h100, 32'h0, 10'h000, 3'd0, "R5");
        op(1, 12'h108, mk(2'b11, 5'd1, 3'd2, 10'h021), 10'h021, 3'd2, "R6");

        // R9: unmapped and misaligned accesses
        op(1, 12'h200, 32'hFFFF_FFFF, 10'h021, 3'd2, "R9");
        op(1, 12'h102, 32'hFFFF_FFFF, 10'h021, 3'd2, "R9");
        op(1, 12'h0FC, 32'hFFFF_FFFF, 10'h021, 3'd2, "R9");
        cmp("R9", "unmapped read", rdata, 32'h0);
        op(0, 12'h000, 32'h0, 10'h021, 3'd2, "R9");
        for (int i = 0; i < N; i++)
            op(0, 12'h100 + 12'(4 * i), 32'h0, 10'h021, 3'd2, "R9");

        // R8: enable clear suppresses the IRQ while entries pend
        op(1, 12'h000, 32'h0000_000E, 10'h0, 3'd0, "R8");
        cmp("R8", "virq gated off", 32'(virq), 32'h0);
        op(1, 12'h000, 32'h0000_0001, 10'h0, 3'd0, "R8");

        // R4: empty everything pending -> none
        op(1, 12'h108, 32'h0, 10'h0, 3'd0, "R4");
        op(1, 12'h10C, 32'h0, 10'h0, 3'd0, "R4");
        cmp("R4", "none pending", 32'(top_valid), 32'h0);
        cmp("R8", "virq no pending", 32'(virq), 32'h0);

        // R8: a fresh pending entry raises the IRQ after its write edge
        op(1, 12'h10C, mk(2'b01, 5'd0, 3'd0, 10'h005), 10'h005, 3'd0, "R8");
        cmp("R8", "virq after write", 32'(virq), 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule